// File: doc/BRIEF.md
# CAN Most-Recent-Event Status Register

This block is a single 8-bit status register in a CAN controller. It remembers what kind of event happened last: a node status transition, a completed transmission or a completed reception. For the two message events it also stores the number of the message buffer involved. Event inputs are one-cycle pulses, one per message buffer for transmit and for receive completion, and one per node-transition condition. Capture does not depend on any interrupt-enable setting. Interrupt generation, the message buffers and the protocol engine are not part of this block.

Software reads the register over a simple bus. It clears a flag by writing 0 to that flag's bit, and a 1 leaves the bit as it is. When the read is the first half of a read-modify-write instruction, the bus marks it with a qualifier. The three flag bits then read as 1, so the write half of a bit-manipulation instruction writes ones back and clears nothing by accident. Only one event kind is held at a time. Events that arrive in the same cycle are arbitrated by a fixed priority, and a hardware set beats a software clear.

The register layout is: bit 7 is the node-transition flag, bit 6 the transmit flag, bit 5 the receive flag, bit 4 is reserved, and bits 3:0 hold the buffer pointer.

Top module: `lei_last_event`

## Requirements
- R1: After reset, all flags and the buffer pointer are zero, so a plain read returns 0x00.
- R2: A pulse on any `rx_done` bit sets bit 5, clears bits 7 and 6, and loads bits 3:0 with the buffer index.
- R3: A pulse on any `tx_done` bit, with no receive pulse in the same cycle, sets bit 6, clears bits 7 and 5, and loads bits 3:0 with the buffer index.
- R4: A pulse on any `node_evt` bit, with no transmit or receive pulse in the same cycle, sets bit 7, clears bits 6 and 5, and leaves bits 3:0 unchanged.
- R5: When event kinds coincide in one cycle, receive wins over transmit, and transmit wins over node transition. At most one flag is ever set.
- R6: When several buffers pulse in the same cycle, the lowest buffer index is captured.
- R7: A write with no event in that cycle clears each flag whose `wdata` bit (7, 6 or 5) is 0. A 1 in that position leaves the flag unchanged. Writes never change bit 4 or the pointer.
- R8: If a hardware event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: A read with `rmw` high returns 1 in bits 7:5 whatever the flags hold, and returns the true bits 4:0. The read itself changes no state.
- R10: Bit 4 always reads 0, and `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done | input | NUM_BUFS | One-cycle pulses, one per buffer, for transmit completion |
| rx_done | input | NUM_BUFS | One-cycle pulses, one per buffer, for receive completion |
| node_evt | input | NUM_NODE_EV | One-cycle pulses, one per node-transition condition |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rmw | input | 1 | Marks the read as the first half of a read-modify-write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the register while `rd_en` is high |

## Verification
The two things that can land in the same cycle are a hardware capture and a software write-clear. Different event kinds can also coincide with each other. The bench pulses a transmit or receive buffer in exactly the cycle that a write carries a 0 in that same flag's bit. A following read must show the flag set and the new pointer. It then fires receive, transmit and node pulses together, and transmit with node, and judges the result by which single flag and which pointer the register holds afterwards.

// File: rtl/lei_pkg.sv
package lei_pkg;

    localparam int unsigned REG_W       = 8;
    localparam int unsigned PTR_FIELD_W = 4;

    // Bit positions visible to software
    localparam int unsigned BIT_NODE = 7;
    localparam int unsigned BIT_TX   = 6;
    localparam int unsigned BIT_RX   = 5;
    localparam int unsigned BIT_RSV  = 4;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_NODE = 2'd1,
        EV_TX   = 2'd2,
        EV_RX   = 2'd3
    } lei_ev_e;

    typedef struct packed {
        logic node;
        logic tx;
        logic rx;
    } lei_flags_t;

    typedef struct packed {
        lei_flags_t               flags;
        logic [PTR_FIELD_W-1:0]   ptr;
    } lei_state_t;

endpackage

// File: rtl/lei_lowest_index.sv
module lei_lowest_index #(
    parameter int unsigned N = 16,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    assign any = |req;

    // Scan downward so the lowest set request is the last to assign
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/lei_event_arbiter.sv
module lei_event_arbiter
    import lei_pkg::*;
#(
    parameter int unsigned NUM_BUFS    = 16,
    parameter int unsigned NUM_NODE_EV = 3
) (
    input  logic [NUM_BUFS-1:0]    tx_done,
    input  logic [NUM_BUFS-1:0]    rx_done,
    input  logic [NUM_NODE_EV-1:0] node_evt,
    output lei_ev_e                ev_sel,
    output logic [PTR_FIELD_W-1:0] ev_ptr
);

    localparam int unsigned IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;

    logic [1:0]       kind_any;
    logic [IDX_W-1:0] kind_idx [2];
    logic             node_any;

    // Index 0: receive, index 1: transmit
    for (genvar k = 0; k < 2; k++) begin : g_kind
        lei_lowest_index #(.N(NUM_BUFS)) u_enc (
            .req (k == 0 ? rx_done : tx_done),
            .any (kind_any[k]),
            .idx (kind_idx[k])
        );
    end

    assign node_any = |node_evt;

    always_comb begin
        ev_sel = EV_NONE;
        ev_ptr = '0;
        if (kind_any[0]) begin
            ev_sel = EV_RX;
            ev_ptr = PTR_FIELD_W'(kind_idx[0]);
        end else if (kind_any[1]) begin
            ev_sel = EV_TX;
            ev_ptr = PTR_FIELD_W'(kind_idx[1]);
        end else if (node_any) begin
            ev_sel = EV_NODE;
        end
    end

endmodule

// File: rtl/lei_read_mux.sv
module lei_read_mux
    import lei_pkg::*;
(
    input  lei_state_t        state,
    input  logic              rd_en,
    input  logic              rmw,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata[BIT_NODE]            = state.flags.node | rmw;
            rdata[BIT_TX]              = state.flags.tx   | rmw;
            rdata[BIT_RX]              = state.flags.rx   | rmw;
            rdata[BIT_RSV]             = 1'b0;
            rdata[PTR_FIELD_W-1:0]     = state.ptr;
        end
    end

endmodule

// File: rtl/lei_last_event.sv
module lei_last_event
    import lei_pkg::*;
#(
    parameter int unsigned NUM_BUFS    = 16,
    parameter int unsigned NUM_NODE_EV = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BUFS-1:0]    tx_done,
    input  logic [NUM_BUFS-1:0]    rx_done,
    input  logic [NUM_NODE_EV-1:0] node_evt,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic                   rmw,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata
);

    lei_state_t state_d, state_q;
    lei_ev_e    ev_sel;
    logic [PTR_FIELD_W-1:0] ev_ptr;
    logic       unused_wbits;

    assign unused_wbits = ^wdata[BIT_RSV:0];

    lei_event_arbiter #(
        .NUM_BUFS    (NUM_BUFS),
        .NUM_NODE_EV (NUM_NODE_EV)
    ) u_arb (
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .node_evt (node_evt),
        .ev_sel   (ev_sel),
        .ev_ptr   (ev_ptr)
    );

    // Next state: a hardware capture overrides any same-cycle write
    always_comb begin
        state_d = state_q;
        unique case (ev_sel)
            EV_RX: begin
                state_d.flags = '{node: 1'b0, tx: 1'b0, rx: 1'b1};
                state_d.ptr   = ev_ptr;
            end
            EV_TX: begin
                state_d.flags = '{node: 1'b0, tx: 1'b1, rx: 1'b0};
                state_d.ptr   = ev_ptr;
            end
            EV_NODE: begin
                state_d.flags = '{node: 1'b1, tx: 1'b0, rx: 1'b0};
            end
            default: begin
                if (wr_en) begin
                    state_d.flags.node = state_q.flags.node & wdata[BIT_NODE];
                    state_d.flags.tx   = state_q.flags.tx   & wdata[BIT_TX];
                    state_d.flags.rx   = state_q.flags.rx   & wdata[BIT_RX];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    lei_read_mux u_rd (
        .state (state_q),
        .rd_en (rd_en),
        .rmw   (rmw),
        .rdata (rdata)
    );

endmodule

// File: rtl/lei_last_event_chk.sv
module lei_last_event_chk #(
    parameter int unsigned NUM_BUFS    = 16,
    parameter int unsigned NUM_NODE_EV = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_BUFS-1:0]    tx_done,
    input logic [NUM_BUFS-1:0]    rx_done,
    input logic [NUM_NODE_EV-1:0] node_evt,
    input logic                   rd_en,
    input logic                   rmw,
    input logic                   wr_en,
    input logic [2:0]             wflags,
    input logic [7:0]             rdata,
    input logic [2:0]             flags_q,
    input logic [3:0]             ptr_q
);

    logic rx_any, tx_any, nd_any;
    assign rx_any = |rx_done;
    assign tx_any = |tx_done;
    assign nd_any = |node_evt;

    a_r2_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rx_any |=> flags_q == 3'b001);

    a_r3_tx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_any && !rx_any) |=> flags_q == 3'b010);

    a_r4_node_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_any && !tx_any && !rx_any) |=> (flags_q == 3'b100 && ptr_q == $past(ptr_q)));

    a_r5_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags_q));

    a_r6_buf0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done[0] |=> ptr_q == 4'd0);

    a_r7_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wflags == 3'b111 && !rx_any && !tx_any && !nd_any)
            |=> ($stable(flags_q) && $stable(ptr_q)));

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wflags[1] && tx_any && !rx_any) |=> flags_q[1]);

    a_r9_rmw_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rmw) |-> rdata[7:5] == 3'b111);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == 8'h00);

    a_r10_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[4] == 1'b0);

endmodule

bind lei_last_event lei_last_event_chk #(
    .NUM_BUFS    (NUM_BUFS),
    .NUM_NODE_EV (NUM_NODE_EV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .node_evt (node_evt),
    .rd_en    (rd_en),
    .rmw      (rmw),
    .wr_en    (wr_en),
    .wflags   (wdata[7:5]),
    .rdata    (rdata),
    .flags_q  (state_q.flags),
    .ptr_q    (state_q.ptr)
);

// File: tb/tb_lei_last_event.sv
module tb_lei_last_event;

    localparam int CLK_PERIOD  = 10;
    localparam int NUM_BUFS    = 16;
    localparam int NUM_NODE_EV = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_BUFS-1:0]    tx_done = '0;
    logic [NUM_BUFS-1:0]    rx_done = '0;
    logic [NUM_NODE_EV-1:0] node_evt = '0;
    logic                   rd_en = 1'b0;
    logic                   wr_en = 1'b0;
    logic                   rmw = 1'b0;
    logic [7:0]             wdata = '0;
    logic [7:0]             rdata;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lei_last_event #(.NUM_BUFS(NUM_BUFS), .NUM_NODE_EV(NUM_NODE_EV)) dut (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done),
        .node_evt(node_evt), .rd_en(rd_en), .wr_en(wr_en), .rmw(rmw),
        .wdata(wdata), .rdata(rdata)
    );

    // Monitor: compares each read against the head of the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            logic [7:0] e;
            string t;
            if (exp_q.size() == 0) begin
                mismatched++;
                compared++;
                $display("FAIL unexpected read: actual %02h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic do_read(input logic m, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1;
        rmw   = m;
        @(posedge clk); #1;
        rd_en = 1'b0;
        rmw   = 1'b0;
    endtask

    // Applies one cycle of events and/or a write, then returns after the capture edge
    task automatic cycle(input logic [NUM_BUFS-1:0] rx, input logic [NUM_BUFS-1:0] tx,
                         input logic [NUM_NODE_EV-1:0] nd, input logic w, input logic [7:0] d);
        rx_done = rx; tx_done = tx; node_evt = nd; wr_en = w; wdata = d;
        @(posedge clk); #1;
        rx_done = '0; tx_done = '0; node_evt = '0; wr_en = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        do_read(1'b0, 8'h00, "R1 reset value");
        do_read(1'b1, 8'hE0, "R9 rmw after reset");

        // idle read port is zero (R10)
        @(negedge clk);
        compared++;
        if (rdata !== 8'h00) begin
            mismatched++;
            $display("FAIL R10 idle rdata: actual %02h expected 00", rdata);
        end
        @(posedge clk); #1;

        cycle(16'h0200, '0, '0, 1'b0, 8'h00);
        do_read(1'b0, 8'h29, "R2 rx buffer 9");

        cycle('0, 16'h1020, '0, 1'b0, 8'h00);
        do_read(1'b0, 8'h45, "R3 R6 tx buffers 5 and 12");

        cycle('0, '0, 3'b010, 1'b0, 8'h00);
        do_read(1'b0, 8'h85, "R4 node keeps pointer");

        do_read(1'b1, 8'hE5, "R9 rmw forces flags");
        do_read(1'b0, 8'h85, "R9 rmw read has no side effect");

        cycle('0, '0, '0, 1'b1, 8'hFF);
        do_read(1'b0, 8'h85, "R7 write ones no effect");

        cycle('0, '0, '0, 1'b1, 8'h7F);
        do_read(1'b0, 8'h05, "R7 write zero clears node");

        cycle('0, '0, '0, 1'b1, 8'hFA);
        do_read(1'b0, 8'h05, "R7 R10 write to bit4 and pointer ignored");

        cycle(16'h0008, 16'h0002, 3'b111, 1'b0, 8'h00);
        do_read(1'b0, 8'h23, "R5 rx beats tx and node");

        cycle('0, 16'h0080, 3'b001, 1'b0, 8'h00);
        do_read(1'b0, 8'h47, "R5 tx beats node");

        cycle('0, 16'h0004, '0, 1'b1, 8'hBF);
        do_read(1'b0, 8'h42, "R8 tx set beats clear");

        cycle(16'h8000, '0, '0, 1'b1, 8'h00);
        do_read(1'b0, 8'h2F, "R8 rx set beats clear");

        cycle('0, '0, '0, 1'b1, 8'h00);
        do_read(1'b0, 8'h0F, "R7 clear all keeps pointer");

        cycle(16'h8001, '0, '0, 1'b0, 8'h00);
        do_read(1'b0, 8'h20, "R6 lowest rx buffer 0");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            mismatched++;
            compared++;
            $display("FAIL scoreboard drain: actual %0d left expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule